// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the series of double-word addresses a memory visits during one synchronous burst read. A start strobe captures a start address together with three configuration fields (ordering, wrap choice and length code). From the next cycle the block presents the current address with a valid flag. Each advance strobe steps it to the next address in the chosen order.

Addresses come out in one of two orders. Sequential order counts up. Interleaved order combines the start offset with the beat index by exclusive-or. A wrapping burst stays inside its aligned block of 4 or 8 double-words and ends after that many beats. The final beat is marked by a last flag. A no-wrap burst, or the unbounded sequential mode, keeps issuing addresses past the block edge until the next start. Latency timing, the storage array and the data path belong to neighbouring blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, valid and last are 0 and addr is 0.
- R2: A start strobe makes the block present start_addr with valid high on the next cycle. This holds even when a burst is in progress or advance is also high, because start aborts the burst.
- R3: While no start and no advance arrive, addr, valid and last keep their values.
- R4: Sequential wrapping order (cfg_seq=1, cfg_nowrap=0) increments only the low 2 bits (length 4) or the low 3 bits (length 8), modulo the length. The upper address bits stay fixed.
- R5: Interleaved wrapping order (cfg_seq=0, cfg_nowrap=0) presents the start address with its low 2 or 3 bits exclusive-ored with the beat index (0, 1, 2, ...).
- R6: Length codes are: cfg_len=3'b001 gives 4, 3'b010 gives 8, and 3'b111 gives an unbounded burst. Every other code gives 4.
- R7: A wrapping burst of length N raises last on beat N-1. An advance on that beat clears valid. An advance while valid is low changes nothing.
- R8: Sequential no-wrap and unbounded bursts add the beat index to the whole start address, rolling over from all ones to zero. They never raise last and never end on their own.
- R9: Interleaved no-wrap bursts exclusive-or the low bits with the beat index modulo N. The block base moves up by N for every N beats, and the burst never ends on its own.
- R10: The unbounded length code with interleaved order behaves exactly as the unbounded sequential burst.
- R11: Configuration fields are sampled only on a start strobe. Changes to them during a burst have no effect on the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture start_addr and configuration, begin a burst |
| start_addr | input | AW | First double-word address of the burst |
| advance | input | 1 | Step to the next address |
| cfg_seq | input | 1 | 1 sequential order, 0 interleaved order |
| cfg_nowrap | input | 1 | 0 wrap within the block, 1 run past the block |
| cfg_len | input | 3 | Length code |
| addr | output | AW | Current double-word address |
| valid | output | 1 | A burst is active and addr is meaningful |
| last | output | 1 | Current beat is the final one of a wrapping burst |

## Verification
The checker assumes start and advance are ordinary synchronous strobes that may be high together. It assumes advance can arrive while no burst is active, and it places no limit on how long a burst runs between strobes. The stimulus covers these conditions. It holds advance off for random gaps and fires a start mid-burst with advance also high. It advances after a burst has ended and alters the configuration inputs while a burst runs. It also uses a start address just below the top of the address space, so the rollover case is reached within a few beats.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic          advance,
  input  logic          cfg_seq,
  input  logic          cfg_nowrap,
  input  logic [2:0]    cfg_len,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic          last
);
  localparam logic [2:0] LEN_EIGHT = 3'b010;
  localparam logic [2:0] LEN_ENDLESS = 3'b111;

  logic [AW-1:0] base_q, beat_q;
  logic          valid_q, seq_q, open_q, eight_q;
  logic [AW-1:0] mask, seq_wrap, seq_open, ilv_wrap, ilv_open;

  assign mask = eight_q ? AW'(7) : AW'(3);

  assign seq_open = base_q + beat_q;
  assign seq_wrap = (base_q & ~mask) | ((base_q + beat_q) & mask);
  assign ilv_wrap = base_q ^ (beat_q & mask);
  assign ilv_open = ((base_q & ~mask) + (beat_q & ~mask)) | ((base_q ^ beat_q) & mask);

  always_comb begin
    case ({seq_q, open_q})
      2'b11:   addr = seq_open;
      2'b10:   addr = seq_wrap;
      2'b01:   addr = ilv_open;
      default: addr = ilv_wrap;
    endcase
  end

  assign valid = valid_q;
  assign last  = valid_q & ~open_q & (beat_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
      seq_q   <= 1'b1;
      open_q  <= 1'b0;
      eight_q <= 1'b0;
    end else if (start) begin
      base_q  <= start_addr;
      beat_q  <= '0;
      valid_q <= 1'b1;
      seq_q   <= cfg_seq | (cfg_len == LEN_ENDLESS);
      open_q  <= cfg_nowrap | (cfg_len == LEN_ENDLESS);
      eight_q <= (cfg_len == LEN_EIGHT);
    end else if (advance && valid_q) begin
      if (last) valid_q <= 1'b0;
      else      beat_q  <= beat_q + AW'(1);
    end
  end
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] start_addr,
  input logic          advance,
  input logic [AW-1:0] addr,
  input logic          valid,
  input logic          last
);
  a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !valid && !last);
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid && addr == $past(start_addr));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !advance && !start |=> valid && $stable(addr) && $stable(last));
  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> valid);
  a_r7_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> $past(last && advance));
  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !valid && !start |=> !valid);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
  .advance(advance), .addr(addr), .valid(valid), .last(last)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, advance = 1'b0, cfg_seq = 1'b1, cfg_nowrap = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [2:0] cfg_len = 3'b001;
  logic [AW-1:0] addr;
  logic valid, last;

  int errors = 0, checks = 0, cycles = 0;
  string tag = "R1";

  int m_base = 0, m_beat = 0, m_len = 4;
  bit m_valid = 0, m_seq = 1, m_open = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .advance(advance), .cfg_seq(cfg_seq), .cfg_nowrap(cfg_nowrap),
    .cfg_len(cfg_len), .addr(addr), .valid(valid), .last(last)
  );

  function automatic int exp_addr();
    int blk, off, k;
    blk = (m_base / m_len) * m_len;
    off = m_base % m_len;
    k = m_beat % m_len;
    if (m_seq && m_open) return (m_base + m_beat) % SPAN;
    if (m_seq) return blk + ((off + m_beat) % m_len);
    if (m_open) return ((blk + (m_beat / m_len) * m_len) % SPAN) + (off ^ k);
    return blk + (off ^ k);
  endfunction

  function automatic bit exp_last();
    return m_valid && !m_open && (m_beat == m_len - 1);
  endfunction

  task automatic compare();
    checks++;
    if (valid !== m_valid || last !== exp_last() ||
        (m_valid && addr !== AW'(exp_addr()))) begin
      errors++;
      $display("FAIL %s: got addr=%h valid=%b last=%b, expected addr=%h valid=%b last=%b",
               tag, addr, valid, last, AW'(exp_addr()), m_valid, exp_last());
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_valid = 0; m_base = 0; m_beat = 0;
    end else if (start) begin
      m_base = int'(start_addr); m_beat = 0; m_valid = 1;
      m_seq = cfg_seq || cfg_len == 3'b111;
      m_open = cfg_nowrap || cfg_len == 3'b111;
      m_len = (cfg_len == 3'b010) ? 8 : 4;
    end else if (advance && m_valid) begin
      if (exp_last()) m_valid = 0;
      else m_beat++;
    end
  endtask

  task automatic cyc(input bit st, input bit adv);
    start = st; advance = adv;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    start = 1'b0; advance = 1'b0;
  endtask

  task automatic begin_burst(input int a, input bit sq, input bit nw, input logic [2:0] ln);
    start_addr = AW'(a); cfg_seq = sq; cfg_nowrap = nw; cfg_len = ln;
    cyc(1, 0);
  endtask

  task automatic run(input int n, input int gap_seed);
    for (int i = 0; i < n; i++) begin
      if (((i + gap_seed) % 3) == 0) cyc(0, 0);
      cyc(0, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; cyc(0, 1); cyc(0, 0);
    rst_n = 1'b1;
    cyc(0, 0);

    tag = "R4"; begin_burst('h1236, 1, 0, 3'b001); run(5, 0);
    tag = "R7"; cyc(0, 1); cyc(0, 0);
    tag = "R4"; begin_burst('h2345, 1, 0, 3'b010); run(9, 1);
    tag = "R5"; begin_burst('h00A5, 0, 0, 3'b010); run(9, 2);
    tag = "R5"; begin_burst('h0F3E, 0, 0, 3'b001); run(4, 0);
    tag = "R3"; cyc(0, 0); cyc(0, 0); cyc(0, 0);
    tag = "R8"; begin_burst('hFFFE, 1, 1, 3'b001); run(7, 1);
    tag = "R8"; begin_burst('hFFFA, 1, 0, 3'b111); run(12, 2);
    tag = "R10"; begin_burst('h0013, 0, 0, 3'b111); run(12, 0);
    tag = "R9"; begin_burst('h0101, 0, 1, 3'b001); run(10, 1);
    tag = "R9"; begin_burst('hFFF5, 0, 1, 3'b010); run(20, 2);
    tag = "R6"; begin_burst('h0402, 1, 0, 3'b000); run(5, 0);
    tag = "R6"; begin_burst('h0807, 0, 0, 3'b101); run(5, 1);
    tag = "R2"; begin_burst('h3001, 1, 0, 3'b010); run(3, 0);
    start_addr = 'h4446; cfg_seq = 0; cfg_nowrap = 0; cfg_len = 3'b001;
    cyc(1, 1); run(5, 2);
    tag = "R11"; begin_burst('h5553, 1, 0, 3'b010);
    cfg_seq = 0; cfg_nowrap = 1; cfg_len = 3'b111; start_addr = 'h0000;
    run(9, 0);
    tag = "R3"; begin_burst('h6660, 0, 0, 3'b001);
    for (int i = 0; i < 4; i++) cyc(0, 0);
    run(4, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule